// File: doc/BRIEF.md
# Nibble-Parallel Transmit Frame Source

This block sits at the transmit input of a line framer. It runs from one line-rate clock (nominally 34.368 MHz) and is the frame timing master: it counts out a free-running 1536-bit frame, produces a nibble clock at one quarter of the line rate for the terminal equipment, and takes in 4-bit payload nibbles from that equipment. Each nibble is captured on the third line-clock rising edge after the nibble clock rises. It is then sent out serially, most significant bit first, in the following nibble period.

The first twelve bits of every frame are overhead: a 10-bit alignment word, then an alarm bit and a national bit taken from static inputs. The terminal equipment learns which nibbles will be thrown away from an overhead indicator. Because a nibble sampled in one period goes out in the next, the indicator leads the overhead slots by one nibble period. A start-of-frame output covers the nibble period of bit 0. A frame-end pulse marks the cycle in which the last bit of the frame is on the serial output.

Top module: `nfr_tx_nibble_in`

## Requirements
- R1: `nib_clk` has one quarter of the line-clock rate. It is high while the bit count modulo 4 is 0 or 1 and low while it is 2 or 3, so it rises at the start of every nibble period.
- R2: `nib_in` is captured only at the line-clock rising edge that ends the cycle with bit count modulo 4 equal to 2, which is the third rising edge after `nib_clk` rises. Values present at any other edge have no effect on `sdo`.
- R3: A nibble captured in nibble period p is sent on `sdo` during period p+1, bit 3 first and bit 0 last, one bit per line-clock cycle.
- R4: The frame is 1536 bits (384 nibble periods). The bit counter wraps from 1535 to 0 with no external alignment.
- R5: Frame bits 0 to 9 carry the alignment word 1111010000, with bit 0 being the leftmost 1. Bit 10 carries `alarm_bit` and bit 11 carries `nat_bit`, each as present during that cycle.
- R6: `oh_ind` is high during nibble periods 383, 0 and 1. The nibbles sampled in those periods never appear on `sdo`, because frame bits 0 to 11 carry overhead instead.
- R7: `sof` is high during frame bits 0 to 3 and low otherwise.
- R8: `frame_end` is high for exactly one line-clock cycle per frame, the cycle in which bit 1535 is on `sdo`.
- R9: A synchronous active-high `rst` holds the bit counter at 0. While it is held, the outputs show bit 0 (`sof`=1, `oh_ind`=1, `nib_clk`=1, `frame_end`=0, `sdo`=1). After release, the first frame starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock, the only timing reference |
| rst | input | 1 | Synchronous active-high reset |
| nib_in | input | 4 | Payload nibble from terminal equipment |
| alarm_bit | input | 1 | Value sent in frame bit 10 |
| nat_bit | input | 1 | Value sent in frame bit 11 |
| nib_clk | output | 1 | Generated nibble clock, line clock divided by 4 |
| oh_ind | output | 1 | High in the nibble periods whose samples are discarded |
| sof | output | 1 | High for the nibble period carrying frame bit 0 |
| frame_end | output | 1 | One-cycle pulse on the last frame bit |
| sdo | output | 1 | Serial frame data |

## Verification
On every cycle, the assertions check local timing relations. They check that the nibble clock stays low for two cycles after it falls, and that the start marker always falls inside the overhead window. They check that a frame-end pulse is followed by the start of a frame whose first serial bit is 1, and that the capture register changes only after the sampling edge. The bench alone shows the whole serial content over several frames against a model. That content is the alignment word, the alarm and national bits, and the capture phase and one-period latency of payload nibbles. The bench also shows that samples taken while the overhead indicator is high are discarded, and that a mid-frame reset restarts the frame cleanly.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
    typedef enum logic [1:0] {
        SLOT_SYNC    = 2'd0,
        SLOT_ALARM   = 2'd1,
        SLOT_NAT     = 2'd2,
        SLOT_PAYLOAD = 2'd3
    } slot_kind_e;
endpackage

// File: rtl/nfr_frame_timer.sv
module nfr_frame_timer #(
    parameter int FRAME_BITS = 1536,
    parameter int NIB_W      = 4,
    parameter int OH_BITS    = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    output logic [$clog2(NIB_W)-1:0]      ph,
    output logic                          nib_clk,
    output logic                          oh_ind,
    output logic                          sof,
    output logic                          frame_end
);
    localparam int CNT_W   = $clog2(FRAME_BITS);
    localparam int PH_W    = $clog2(NIB_W);
    localparam int PER_W   = CNT_W - PH_W;
    localparam int NPER    = FRAME_BITS / NIB_W;
    localparam int OH_NIBS = OH_BITS / NIB_W;

    typedef struct packed {
        logic [CNT_W-1:0] bit_cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [PER_W-1:0] period, period_nx;

    always_comb begin
        st_d = st_q;
        if (st_q.bit_cnt == CNT_W'(FRAME_BITS - 1))
            st_d.bit_cnt = '0;
        else
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
        if (rst)
            st_d.bit_cnt = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        bit_idx   = st_q.bit_cnt;
        ph        = st_q.bit_cnt[PH_W-1:0];
        period    = st_q.bit_cnt[CNT_W-1:PH_W];
        period_nx = (period == PER_W'(NPER - 1)) ? '0 : period + 1'b1;
        nib_clk   = (ph < PH_W'(NIB_W / 2));
        oh_ind    = (period_nx < PER_W'(OH_NIBS));
        sof       = (period == '0);
        frame_end = (st_q.bit_cnt == CNT_W'(FRAME_BITS - 1));
    end

    // R1
    nibclk_low_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nib_clk) |=> !nib_clk);

    // R7
    sof_in_overhead_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> oh_ind);

    // R8
    end_then_start_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (sof && nib_clk));

    // R8
    end_on_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> !nib_clk);
endmodule

// File: rtl/nfr_nibble_capture.sv
module nfr_nibble_capture #(
    parameter int NIB_W       = 4,
    parameter int SAMPLE_EDGE = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NIB_W)-1:0] ph,
    input  logic [NIB_W-1:0]         nib_in,
    output logic [NIB_W-1:0]         out_nib
);
    localparam int PH_W      = $clog2(NIB_W);
    localparam int SAMPLE_PH = SAMPLE_EDGE - 1;
    localparam int LOAD_PH   = NIB_W - 1;

    typedef struct packed {
        logic [NIB_W-1:0] hold;
        logic [NIB_W-1:0] shout;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ph == PH_W'(SAMPLE_PH))
            st_d.hold = nib_in;
        if (ph == PH_W'(LOAD_PH))
            st_d.shout = st_q.hold;
        if (rst) begin
            st_d.hold  = '0;
            st_d.shout = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_nib = st_q.shout;

    // R2
    hold_only_at_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_W'(SAMPLE_PH)) |=> $stable(st_q.hold));

    // R3
    out_steady_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_W'(LOAD_PH)) |=> $stable(out_nib));
endmodule

// File: rtl/nfr_ovh_insert.sv
module nfr_ovh_insert
    import nfr_pkg::*;
#(
    parameter int                 FRAME_BITS = 1536,
    parameter int                 NIB_W      = 4,
    parameter int                 SYNC_W     = 10,
    parameter logic [SYNC_W-1:0]  SYNC_WORD  = 10'b1111010000
) (
    input  logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    input  logic [$clog2(NIB_W)-1:0]      ph,
    input  logic [NIB_W-1:0]              out_nib,
    input  logic                          alarm_bit,
    input  logic                          nat_bit,
    output logic                          sdo
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    slot_kind_e       kind;
    logic [SYNC_W-1:0] sync_sh;
    logic [NIB_W-1:0]  nib_sh;

    always_comb begin
        if (bit_idx < CNT_W'(SYNC_W))
            kind = SLOT_SYNC;
        else if (bit_idx == CNT_W'(SYNC_W))
            kind = SLOT_ALARM;
        else if (bit_idx == CNT_W'(SYNC_W + 1))
            kind = SLOT_NAT;
        else
            kind = SLOT_PAYLOAD;

        sync_sh = SYNC_WORD << bit_idx;
        nib_sh  = out_nib << ph;

        unique case (kind)
            SLOT_SYNC:  sdo = sync_sh[SYNC_W-1];
            SLOT_ALARM: sdo = alarm_bit;
            SLOT_NAT:   sdo = nat_bit;
            default:    sdo = nib_sh[NIB_W-1];
        endcase
    end
endmodule

// File: rtl/nfr_tx_nibble_in.sv
module nfr_tx_nibble_in #(
    parameter int FRAME_BITS  = 1536,
    parameter int NIB_W       = 4,
    parameter int SYNC_W      = 10,
    parameter int SAMPLE_EDGE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             alarm_bit,
    input  logic             nat_bit,
    output logic             nib_clk,
    output logic             oh_ind,
    output logic             sof,
    output logic             frame_end,
    output logic             sdo
);
    localparam int CNT_W   = $clog2(FRAME_BITS);
    localparam int PH_W    = $clog2(NIB_W);
    localparam int OH_BITS = SYNC_W + 2;

    logic [CNT_W-1:0] bit_idx;
    logic [PH_W-1:0]  ph;
    logic [NIB_W-1:0] out_nib;

    nfr_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .NIB_W      (NIB_W),
        .OH_BITS    (OH_BITS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .bit_idx   (bit_idx),
        .ph        (ph),
        .nib_clk   (nib_clk),
        .oh_ind    (oh_ind),
        .sof       (sof),
        .frame_end (frame_end)
    );

    nfr_nibble_capture #(
        .NIB_W       (NIB_W),
        .SAMPLE_EDGE (SAMPLE_EDGE)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .nib_in  (nib_in),
        .out_nib (out_nib)
    );

    nfr_ovh_insert #(
        .FRAME_BITS (FRAME_BITS),
        .NIB_W      (NIB_W),
        .SYNC_W     (SYNC_W)
    ) u_ovh (
        .bit_idx   (bit_idx),
        .ph        (ph),
        .out_nib   (out_nib),
        .alarm_bit (alarm_bit),
        .nat_bit   (nat_bit),
        .sdo       (sdo)
    );

    // R5
    frame_opens_with_one_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> sdo);

    // R6
    overhead_window_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> oh_ind);
endmodule

// File: tb/nfr_tx_nibble_in_bench.sv
module nfr_tx_nibble_in_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 1536;
    localparam logic [9:0] SYNC = 10'b1111010000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nib_in = '0;
    logic       alarm_bit = 1'b0;
    logic       nat_bit = 1'b0;
    logic       nib_clk, oh_ind, sof, frame_end, sdo;

    int vectors = 0;
    int errors  = 0;
    int k = 0;
    logic [3:0] samp_cur = '0;
    logic [3:0] samp_prev = '0;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nfr_tx_nibble_in u_nfr_tx_nibble_in (
        .clk       (clk),
        .rst       (rst),
        .nib_in    (nib_in),
        .alarm_bit (alarm_bit),
        .nat_bit   (nat_bit),
        .nib_clk   (nib_clk),
        .oh_ind    (oh_ind),
        .sof       (sof),
        .frame_end (frame_end),
        .sdo       (sdo)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, k, act, exp);
        end
    endtask

    function automatic logic f_nibclk(int b); return (b % 4) < 2; endfunction
    function automatic logic f_sof(int b); return b < 4; endfunction
    function automatic logic f_fend(int b); return b == FRAME - 1; endfunction
    function automatic logic f_oh(int b);
        int p = b / 4;
        return (p == 383) || (p < 2);
    endfunction
    function automatic logic f_sdo(int b, logic [3:0] prev, logic al, logic na);
        if (b < 10) return SYNC[9 - b];
        if (b == 10) return al;
        if (b == 11) return na;
        return prev[3 - (b % 4)];
    endfunction

    // Outputs checked at negedge; new inputs driven right after.
    task automatic run_cycles(input int n, input bit directed_hold);
        for (int i = 0; i < n; i++) begin
            int b = k % FRAME;
            if (b % 4 == 0) samp_prev = samp_cur;
            check("R1 nib_clk", int'(nib_clk), int'(f_nibclk(b)));
            check("R7 sof", int'(sof), int'(f_sof(b)));
            check("R8/R4 frame_end", int'(frame_end), int'(f_fend(b)));
            check("R6 oh_ind", int'(oh_ind), int'(f_oh(b)));
            if (b < 12)
                check("R5/R6 overhead sdo", int'(sdo), int'(f_sdo(b, samp_prev, alarm_bit, nat_bit)));
            else
                check("R3/R2 payload sdo", int'(sdo), int'(f_sdo(b, samp_prev, alarm_bit, nat_bit)));
            if (directed_hold && (b % 4 != 2))
                nib_in = ~samp_cur;      // R2: off-phase values must be ignored
            else
                nib_in = 4'($urandom());
            if (b % 4 == 2) samp_cur = nib_in;
            if (b == 200) begin
                alarm_bit = 1'($urandom());
                nat_bit   = 1'($urandom());
            end
            @(negedge clk);
            k++;
        end
    endtask

    task automatic check_reset_state();
        check("R9 reset sof", int'(sof), 1);
        check("R9 reset oh_ind", int'(oh_ind), 1);
        check("R9 reset nib_clk", int'(nib_clk), 1);
        check("R9 reset frame_end", int'(frame_end), 0);
        check("R9 reset sdo", int'(sdo), 1);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1d5e_ed07);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        k = 0;
        run_cycles(FRAME + 300, 1'b0);
        run_cycles(800, 1'b1);
        alarm_bit = 1'b1; nat_bit = 1'b0;
        run_cycles(FRAME * 2 - 1100 - (k % FRAME) + 20, 1'b0);
        // R9: mid-frame synchronous reset
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        k = 0;
        alarm_bit = 1'b0; nat_bit = 1'b1;
        run_cycles(FRAME + 40, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule